// File: doc/BRIEF.md
# Phase-Selectable Divide-by-Two Clock Generator

This block takes a reference clock and produces a set of output clocks, each at half the reference frequency with an even duty cycle. A select bit for each output chooses the phase of that output. When the bit is 1, the output runs in step with the internal divided clock. When the bit is 0, it runs in the opposite phase. If every select bit is 0, the block parks all outputs low. An active-low power-down input also parks all outputs low.

Select and power-down changes are never applied in the middle of an output period. The block samples both on the rising edge of the reference clock, optionally through a short synchronizer chain. It applies the new state only on the edge that opens an output period. As a result, no output ever shows a pulse shorter than one reference period, and all outputs switch pattern together. Every output comes straight from a register clocked by the reference clock, so no output is gated combinationally.

Top module: `pcg_phase_clkgen`

## Requirements
- R1: While an output is enabled and its select state is unchanged, it toggles on every reference rising edge. Its period is therefore two reference cycles, high for one and low for one.
- R2: Output periods open on every second rising edge, starting with the first edge after reset is released. On an opening edge with power-down high and a non-zero select, output n goes high if select bit n is 1 and low if it is 0. Each output then inverts on the following edge.
- R3: A select value of all zeros, loaded on an opening edge, drives every output low for the whole output period.
- R4: Power-down low, loaded on an opening edge, drives every output low for the whole output period.
- R5: Select and power-down are sampled on reference rising edges and take effect only on an opening edge. On the edge between two opening edges, the outputs either all invert (enabled) or all stay low (parked).
- R6: A new select value that is held stable appears on the outputs within SYNC_STAGES+2 rising edges, counting the first edge that samples it. With the default SYNC_STAGES=0, this means within 2 edges.
- R7: Releasing power-down, with a non-zero select held, restarts the outputs within the same SYNC_STAGES+2 edge bound.
- R8: The asynchronous active-low reset drives every output low at once and keeps them low while it is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_sel | input | NUM_OUT | Per-output phase select: 1 = in-phase, 0 = opposite phase; all zeros parks all outputs |
| pwr_n | input | 1 | Power-down, active low; low parks all outputs |
| clk_out | output | NUM_OUT | Divided output clocks |

## Verification
The hardest case to reach is a change on the inputs that arrives one edge before an opening edge, compared with one that arrives exactly on an opening edge. These two cases give different latencies and different first output levels. The stimulus drives inputs one reference cycle at a time, and the bench tracks the parity of edges since reset. The directed latency checks are therefore placed deliberately at both parities. The long random phase then changes select and power-down on arbitrary cycles, including back-to-back changes that overwrite a value before it was ever loaded.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

   // Upper limits checked at elaboration
   localparam int unsigned PCG_MAX_OUT  = 32;
   localparam int unsigned PCG_MAX_SYNC = 3;

   // State of the divide-by-two flop before an edge:
   // PH_OPEN means the coming edge starts a new output period.
   typedef enum logic {
      PH_OPEN  = 1'b0,
      PH_CLOSE = 1'b1
   } pcg_phase_e;

   // Level an output takes after the edge, given the enable, its phase
   // choice and the divider value after the same edge.
   function automatic logic pcg_level(input logic on,
                                      input logic want_true,
                                      input logic div_nx);
      return on & (want_true ? div_nx : ~div_nx);
   endfunction

endpackage

// File: rtl/pcg_sync.sv
module pcg_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         // Inputs already meet setup/hold to clk; the next register samples them
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];

         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stage_q[s] <= '0;
               end else if (s == 0) begin
                  stage_q[s] <= d;
               end else begin
                  stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
               end
            end
         end

         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pcg_divider.sv
module pcg_divider
   import pcg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   output logic div_q,
   output logic div_nx,
   output logic open_edge
);

   pcg_phase_e ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_OPEN;
      end else begin
         ph_q <= (ph_q == PH_OPEN) ? PH_CLOSE : PH_OPEN;
      end
   end

   assign div_q     = logic'(ph_q);
   assign div_nx    = ~div_q;
   assign open_edge = (ph_q == PH_OPEN);

endmodule

// File: rtl/pcg_state.sv
module pcg_state #(
   parameter int unsigned NUM_OUT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               open_edge,
   input  logic [NUM_OUT-1:0] sel_s,
   input  logic               pwr_s,
   output logic [NUM_OUT-1:0] act_nx,
   output logic               on_nx
);

   logic [NUM_OUT-1:0] act_q;
   logic               on_q;
   logic               on_load;

   // Running needs power and at least one selected phase
   assign on_load = pwr_s & (|sel_s);

   // New state is accepted only where an output period opens
   assign act_nx = open_edge ? sel_s   : act_q;
   assign on_nx  = open_edge ? on_load : on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         on_q  <= 1'b0;
      end else begin
         act_q <= act_nx;
         on_q  <= on_nx;
      end
   end

endmodule

// File: rtl/pcg_drive.sv
module pcg_drive
   import pcg_pkg::*;
#(
   parameter int unsigned NUM_OUT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               on_nx,
   input  logic               div_nx,
   input  logic [NUM_OUT-1:0] act_nx,
   output logic [NUM_OUT-1:0] clk_out
);

   generate
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
         // One flop per output: equal clock-to-out path for every lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_out[i] <= 1'b0;
            end else begin
               clk_out[i] <= pcg_level(on_nx, act_nx[i], div_nx);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pcg_phase_clkgen.sv
module pcg_phase_clkgen
   import pcg_pkg::*;
#(
   parameter int unsigned NUM_OUT     = 4,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic               clk_in,
   input  logic               rst_n,
   input  logic [NUM_OUT-1:0] phase_sel,
   input  logic               pwr_n,
   output logic [NUM_OUT-1:0] clk_out
);

   localparam int unsigned CTRL_W = NUM_OUT + 1;

   generate
      if (NUM_OUT < 1 || NUM_OUT > PCG_MAX_OUT) begin : g_bad_num_out
         $error("pcg_phase_clkgen: NUM_OUT out of range");
      end
      if (SYNC_STAGES > PCG_MAX_SYNC) begin : g_bad_sync
         $error("pcg_phase_clkgen: SYNC_STAGES out of range");
      end
   endgenerate

   logic [CTRL_W-1:0]  ctrl_s;
   logic [NUM_OUT-1:0] sel_s;
   logic               pd_s;
   logic               div_q;
   logic               div_nx;
   logic               open_edge;
   logic [NUM_OUT-1:0] act_nx;
   logic               on_nx;

   pcg_sync #(
      .WIDTH  (CTRL_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk_in),
      .rst_n (rst_n),
      .d     ({pwr_n, phase_sel}),
      .q     (ctrl_s)
   );

   assign sel_s = ctrl_s[NUM_OUT-1:0];
   assign pd_s  = ctrl_s[NUM_OUT];

   pcg_divider u_div (
      .clk       (clk_in),
      .rst_n     (rst_n),
      .div_q     (div_q),
      .div_nx    (div_nx),
      .open_edge (open_edge)
   );

   pcg_state #(
      .NUM_OUT (NUM_OUT)
   ) u_state (
      .clk       (clk_in),
      .rst_n     (rst_n),
      .open_edge (open_edge),
      .sel_s     (sel_s),
      .pwr_s     (pd_s),
      .act_nx    (act_nx),
      .on_nx     (on_nx)
   );

   pcg_drive #(
      .NUM_OUT (NUM_OUT)
   ) u_drive (
      .clk     (clk_in),
      .rst_n   (rst_n),
      .on_nx   (on_nx),
      .div_nx  (div_nx),
      .act_nx  (act_nx),
      .clk_out (clk_out)
   );

endmodule

// File: rtl/pcg_phase_clkgen_chk.sv
module pcg_phase_clkgen_chk #(
   parameter int unsigned NUM_OUT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_OUT-1:0] out,
   input logic               div_q,
   input logic [NUM_OUT-1:0] sel_s,
   input logic               pd_s
);

   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   // R1: the divider flop alternates on every edge
   p_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (div_q != $past(div_q)));

   // R2: at an opening edge the outputs take the select pattern
   p_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !$past(div_q) && $past(pd_s) && ($past(sel_s) != '0))
      |-> (out == $past(sel_s)));

   // R3: an all-zero select parks every output
   p_allzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !$past(div_q) && ($past(sel_s) == '0)) |-> (out == '0));

   // R4: power-down parks every output
   p_pwrdn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !$past(div_q) && !$past(pd_s)) |-> (out == '0));

   // R5: mid-period edges invert a running pattern
   p_hold_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(div_q) && ($past(out) != '0)) |-> (out == ~$past(out)));

   // R5: mid-period edges keep a parked pattern parked
   p_hold_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(div_q) && ($past(out) == '0)) |-> (out == '0));

   // R8: outputs low while reset is held
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         p_reset_r8: assert (out == '0)
            else $error("outputs not low during reset");
      end
   end

endmodule

bind pcg_phase_clkgen pcg_phase_clkgen_chk #(
   .NUM_OUT (NUM_OUT)
) u_chk (
   .clk   (clk_in),
   .rst_n (rst_n),
   .out   (clk_out),
   .div_q (div_q),
   .sel_s (sel_s),
   .pd_s  (pd_s)
);

// File: tb/sim_pcg_phase_clkgen.sv
module sim_pcg_phase_clkgen;

   localparam int N = 4;

   logic         clk;
   logic         rst_n;
   logic [N-1:0] phase_sel;
   logic         pwr_n;
   logic [N-1:0] clk_out;

   int errors = 0;
   int checks = 0;

   // scoreboard
   logic [N-1:0] q_exp [$];
   string        q_tag [$];

   // bench model state
   logic         m_open;   // next edge opens an output period
   logic         m_on;
   logic [N-1:0] m_prev;

   pcg_phase_clkgen #(.NUM_OUT(N), .SYNC_STAGES(0)) u0 (
      .clk_in    (clk),
      .rst_n     (rst_n),
      .phase_sel (phase_sel),
      .pwr_n     (pwr_n),
      .clk_out   (clk_out)
   );

   initial begin
      clk = 1'b1;
      forever #5 clk = ~clk;
   end

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: clk_out=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // monitor: compare each edge's result
   always @(negedge clk) begin
      if (q_exp.size() > 0) begin
         logic [N-1:0] e;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         check(t, clk_out, e);
      end
   end

   // driver: apply one cycle of inputs and push the expected output
   task automatic step(input logic [N-1:0] s, input logic p);
      logic [N-1:0] e;
      string t;
      phase_sel = s;
      pwr_n     = p;
      if (m_open) begin
         m_on = p && (s != '0);
         e    = m_on ? s : '0;
         t    = !p ? "R4" : ((s == '0) ? "R3" : "R2");
      end else begin
         e = m_on ? ~m_prev : '0;
         t = m_on ? "R1" : "R5";
      end
      m_prev = e;
      m_open = ~m_open;
      q_exp.push_back(e);
      q_tag.push_back(t);
      @(negedge clk);
      #1;
   endtask

   task automatic model_reset();
      m_open = 1'b1;
      m_on   = 1'b0;
      m_prev = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      rst_n     = 1'b0;
      phase_sel = '0;
      pwr_n     = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      #1;
      // R8: reset holds outputs low
      check("R8", clk_out, '0);
      rst_n = 1'b1;

      // R2 / R1: several phase patterns
      repeat (6) step(4'b0101, 1'b1);
      repeat (4) step(4'b1111, 1'b1);
      repeat (4) step(4'b0001, 1'b1);
      repeat (4) step(4'b1000, 1'b1);
      // R3: all-zero select
      repeat (4) step(4'b0000, 1'b1);
      // R4: power-down
      repeat (4) step(4'b1010, 1'b0);

      // R6: select latency, change applied before an opening edge
      repeat (4) step(4'b0011, 1'b1);
      step(4'b0110, 1'b1);
      step(4'b0110, 1'b1);
      checks++;
      if (clk_out != 4'b0110 && clk_out != 4'b1001) begin
         errors++;
         $display("FAIL R6: clk_out=%b expected 0110 or 1001", clk_out);
      end
      // R6: change applied before a mid-period edge
      step(4'b0110, 1'b1);
      step(4'b1100, 1'b1);
      step(4'b1100, 1'b1);
      checks++;
      if (clk_out != 4'b1100 && clk_out != 4'b0011) begin
         errors++;
         $display("FAIL R6: clk_out=%b expected 1100 or 0011", clk_out);
      end

      // R7: power-down release latency, both parities
      repeat (4) step(4'b1001, 1'b0);
      step(4'b1001, 1'b1);
      step(4'b1001, 1'b1);
      checks++;
      if (clk_out != 4'b1001 && clk_out != 4'b0110) begin
         errors++;
         $display("FAIL R7: clk_out=%b expected 1001 or 0110", clk_out);
      end
      repeat (3) step(4'b1001, 1'b0);
      step(4'b0100, 1'b1);
      step(4'b0100, 1'b1);
      checks++;
      if (clk_out != 4'b0100 && clk_out != 4'b1011) begin
         errors++;
         $display("FAIL R7: clk_out=%b expected 0100 or 1011", clk_out);
      end

      // R5: random changes on arbitrary cycles
      begin
         logic [N-1:0] rs;
         logic         rp;
         rs = 4'b0101;
         rp = 1'b1;
         for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 3) == 0) rs = N'($urandom_range(0, 15));
            if ($urandom_range(0, 7) == 0) rp = ~rp;
            step(rs, rp);
         end
      end

      // R8: reset in mid-run clears outputs at once
      repeat (2) step(4'b1110, 1'b1);
      rst_n = 1'b0;
      #1;
      check("R8", clk_out, '0);
      @(negedge clk);
      #1;
      check("R8", clk_out, '0);
      model_reset();
      rst_n = 1'b1;
      repeat (6) step(4'b0010, 1'b1);
      repeat (2) step(4'b0010, 1'b1);

      summary();
   end

endmodule